// File: doc/BRIEF.md
# Microstepping Phase Table Sequencer

This block turns step requests into the winding drive pattern for a two-winding stepper motor. It keeps a 7-bit position pointer into a 128-slot electrical cycle, where each slot is 2.8125 electrical degrees. Each falling edge on the active-low step strobe moves the pointer forward or back. The distance moved depends on a 3-bit resolution code, from a whole step of 32 slots down to a 1/32 microstep of one slot.

From the pointer the block derives four phase-polarity bits for the two H-bridges, plus one 8-bit duty magnitude per winding. The magnitudes follow the absolute cosine (winding A) and absolute sine (winding B) of the electrical angle. The block also drives an active-low home flag. The magnitudes feed a separate PWM stage, which also receives a one-cycle pulse each time a step is taken. Current chopping and sensing are handled elsewhere.

Top module: `ustep_sequencer`

## Requirements
- R1: Resolution codes 3'b101, 3'b110 and 3'b111 all behave as 1/32 stepping, moving the pointer by 1 slot per step.
- R2: Resolution codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b100 move the pointer by 32, 16, 8, 4 and 2 slots per step respectively.
- R3: With `dir` high a step adds the stride, and with `dir` low it subtracts the stride. The pointer wraps modulo 128 in both directions.
- R4: A synchronous active-low reset puts the pointer at slot 0. The outputs then show `phase`=4'b1010, `duty_a`=255, `duty_b`=0 and `home_n`=0.
- R5: `home_n` is 0 exactly when the pointer is at slot 0, and is 1 otherwise.
- R6: `phase` = {bridge A left, bridge A right, bridge B left, bridge B right}. It is 4'b1010 for slots 0–31, 4'b0110 for 32–63, 4'b0101 for 64–95 and 4'b1001 for 96–127.
- R7: `duty_a` = round(255·|cos(p·2.8125°)|) and `duty_b` = round(255·|sin(p·2.8125°)|) for pointer p. Both are 180 at slot 16.
- R8: Each falling edge of `step_n` gives exactly one move, whatever the hold time (at least 8 cycles low). The new pointer shows on the outputs on the third rising clock edge after `step_n` is first sampled low. `step_taken` is high for exactly one cycle per move.
- R9: Changing the resolution code does not realign the pointer: the next stride is added to the pointer's current slot, which may be odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_n | input | 1 | Active-low step strobe, asynchronous to clk |
| dir | input | 1 | 1 = forward (add stride), 0 = reverse |
| mode | input | 3 | Step resolution code |
| phase | output | 4 | Phase polarity {A left, A right, B left, B right} |
| duty_a | output | 8 | Winding A duty magnitude, absolute cosine |
| duty_b | output | 8 | Winding B duty magnitude, absolute sine |
| home_n | output | 1 | Low while the pointer is at slot 0 |
| step_taken | output | 1 | One-cycle pulse when the pointer moves |

## Verification
The bench builds the block with its defaults: a 7-bit pointer and a two-flop strobe synchroniser. Both wrap points (0 to 127 in reverse, 127 to 0 forward) and every quadrant boundary are therefore reachable within a few strides. Directed steps cover all eight resolution codes, including the three that alias to 1/32. They also move to an odd slot and then take coarse strides, to show that the pointer is not realigned. A long run of random steps with random direction and resolution checks the phase pattern, both magnitudes and the home flag against sine and cosine computed in real arithmetic.

// File: rtl/ustep_pkg.sv
// Package: shared sizes for the microstepping sequencer.
// Assumes a 128-slot electrical cycle split into four 32-slot quadrants.
package ustep_pkg;
    localparam int PTR_W   = 7;
    localparam int DUTY_W  = 8;
    localparam int QTR_LOG = PTR_W - 2;
    localparam int QTR_LEN = 1 << QTR_LOG;
    localparam int ROM_AW  = QTR_LOG + 1;
    localparam int MODE_W  = 3;
endpackage

// File: rtl/ustep_edge_sync.sv
// Module: synchronises the active-low step strobe and detects its falling edge.
// Assumes the strobe idles high and each level lasts well beyond STAGES cycles.
module ustep_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw strobe through the synchroniser chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_n};
        end
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A high-to-low transition of the synchronised strobe marks one request.
    always_comb fall_o = prev_q & ~sync_q[STAGES-1];

    // R8: a detected edge is never followed at once by another one.
    p_one_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/ustep_pointer.sv
// Module: position pointer; moves by a resolution-dependent stride per request.
// Assumes mode and dir are steady in the cycle where adv_i is high.
module ustep_pointer
    import ustep_pkg::*;
#(
    parameter int W    = PTR_W,
    parameter int QLOG = QTR_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              fwd_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [W-1:0]      ptr_o,
    output logic              taken_o
);
    logic [MODE_W-1:0] res;
    logic [W-1:0]      stride;
    logic [W-1:0]      ptr_q;
    logic [W-1:0]      ptr_next;
    logic              taken_q;

    // Clamp the resolution code so that all codes above the finest alias to it.
    always_comb res = (mode_i > MODE_W'(QLOG)) ? MODE_W'(QLOG) : mode_i;

    // Stride halves with each finer resolution, from a quarter cycle down to 1.
    always_comb stride = W'(1) << (MODE_W'(QLOG) - res);

    // Next slot, with natural modulo wrap in either direction.
    always_comb ptr_next = fwd_i ? (ptr_q + stride) : (ptr_q - stride);

    // Pointer register: home on reset, moves only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv_i) begin
            ptr_q <= ptr_next;
        end
    end

    // One-cycle notice to the PWM stage, aligned with the new pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
        end else begin
            taken_q <= adv_i;
        end
    end

    always_comb ptr_o   = ptr_q;
    always_comb taken_o = taken_q;

    // R8: pointer holds still without a request.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(ptr_q));
    // R3: forward move lands stride ahead, modulo the cycle.
    p_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && fwd_i) |=> ptr_q == W'($past(ptr_q) + $past(stride)));
    // R3: reverse move lands stride behind, modulo the cycle.
    p_rev_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !fwd_i) |=> ptr_q == W'($past(ptr_q) - $past(stride)));
    // R1: aliased fine codes always move by exactly one slot.
    p_alias_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && fwd_i && mode_i >= MODE_W'(QLOG)) |=> ptr_q == W'($past(ptr_q) + 1'b1));
    // R8: every request moves the pointer and raises the notice.
    p_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (ptr_q != $past(ptr_q)) && taken_q);
    // R2: stride is a single power of two.
    p_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stride) == 1);
endmodule

// File: rtl/ustep_phase_map.sv
// Module: decodes pointer into quadrant polarity, mirrored ROM addresses, home.
// Assumes a quarter-wave sine ROM holding QTR_LEN+1 points (0 to 90 degrees).
module ustep_phase_map
    import ustep_pkg::*;
#(
    parameter int W    = PTR_W,
    parameter int QLOG = QTR_LOG
) (
    input  logic [W-1:0]    ptr_i,
    output logic [3:0]      phase_o,
    output logic [QLOG:0]   cos_addr_o,
    output logic [QLOG:0]   sin_addr_o,
    output logic            home_n_o
);
    localparam logic [QLOG:0] QFULL = (QLOG+1)'(1 << QLOG);

    logic [1:0]      quad;
    logic [QLOG:0]   fwd_addr;
    logic [QLOG:0]   rev_addr;

    // Split the pointer into quadrant and offset within the quadrant.
    always_comb begin
        quad     = ptr_i[W-1:W-2];
        fwd_addr = {1'b0, ptr_i[QLOG-1:0]};
        rev_addr = QFULL - {1'b0, ptr_i[QLOG-1:0]};
    end

    // Bridge polarity per quadrant, following the sign of cos and sin.
    always_comb begin
        unique case (quad)
            2'd0:    phase_o = 4'b1010;
            2'd1:    phase_o = 4'b0110;
            2'd2:    phase_o = 4'b0101;
            default: phase_o = 4'b1001;
        endcase
    end

    // Odd quadrants swap the mirrored and direct addresses.
    always_comb begin
        if (quad[0]) begin
            sin_addr_o = rev_addr;
            cos_addr_o = fwd_addr;
        end else begin
            sin_addr_o = fwd_addr;
            cos_addr_o = rev_addr;
        end
    end

    // Home flag is low only at slot zero.
    always_comb home_n_o = (ptr_i != '0);

    // R6: each bridge has exactly one side driven high.
    always_comb begin
        a_r6: assert ((phase_o[3] ^ phase_o[2]) && (phase_o[1] ^ phase_o[0]));
    end
endmodule

// File: rtl/ustep_quarter_rom.sv
// Module: quarter-wave sine magnitudes, round(255*sin(k*2.8125 deg)), k = 0..32.
// Assumes addresses above 32 are never presented.
module ustep_quarter_rom
    import ustep_pkg::*;
(
    input  logic [ROM_AW-1:0] addr_i,
    output logic [DUTY_W-1:0] mag_o
);
    // Constant lookup of the quarter sine.
    always_comb begin
        unique case (addr_i)
            6'd0:  mag_o = 8'd0;
            6'd1:  mag_o = 8'd13;
            6'd2:  mag_o = 8'd25;
            6'd3:  mag_o = 8'd37;
            6'd4:  mag_o = 8'd50;
            6'd5:  mag_o = 8'd62;
            6'd6:  mag_o = 8'd74;
            6'd7:  mag_o = 8'd86;
            6'd8:  mag_o = 8'd98;
            6'd9:  mag_o = 8'd109;
            6'd10: mag_o = 8'd120;
            6'd11: mag_o = 8'd131;
            6'd12: mag_o = 8'd142;
            6'd13: mag_o = 8'd152;
            6'd14: mag_o = 8'd162;
            6'd15: mag_o = 8'd171;
            6'd16: mag_o = 8'd180;
            6'd17: mag_o = 8'd189;
            6'd18: mag_o = 8'd197;
            6'd19: mag_o = 8'd205;
            6'd20: mag_o = 8'd212;
            6'd21: mag_o = 8'd219;
            6'd22: mag_o = 8'd225;
            6'd23: mag_o = 8'd231;
            6'd24: mag_o = 8'd236;
            6'd25: mag_o = 8'd240;
            6'd26: mag_o = 8'd244;
            6'd27: mag_o = 8'd247;
            6'd28: mag_o = 8'd250;
            6'd29: mag_o = 8'd252;
            6'd30: mag_o = 8'd254;
            6'd31: mag_o = 8'd255;
            6'd32: mag_o = 8'd255;
            default: mag_o = 8'd0;
        endcase
    end
endmodule

// File: rtl/ustep_sequencer.sv
// Module: top of the microstepping sequencer; strobe sync, pointer, decode, ROMs.
// Assumes step_n pulses hold each level for at least 8 clock cycles.
module ustep_sequencer
    import ustep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_n,
    input  logic              dir,
    input  logic [MODE_W-1:0] mode,
    output logic [3:0]        phase,
    output logic [DUTY_W-1:0] duty_a,
    output logic [DUTY_W-1:0] duty_b,
    output logic              home_n,
    output logic              step_taken
);
    logic              adv;
    logic [PTR_W-1:0]  ptr;
    logic [ROM_AW-1:0] rom_addr [2];
    logic [DUTY_W-1:0] rom_mag  [2];

    ustep_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (step_n),
        .fall_o   (adv)
    );

    ustep_pointer u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .fwd_i   (dir),
        .mode_i  (mode),
        .ptr_o   (ptr),
        .taken_o (step_taken)
    );

    ustep_phase_map u_map (
        .ptr_i      (ptr),
        .phase_o    (phase),
        .cos_addr_o (rom_addr[0]),
        .sin_addr_o (rom_addr[1]),
        .home_n_o   (home_n)
    );

    // One quarter-wave ROM per winding: index 0 is cosine, index 1 is sine.
    for (genvar w = 0; w < 2; w++) begin : g_wind
        ustep_quarter_rom u_rom (
            .addr_i (rom_addr[w]),
            .mag_o  (rom_mag[w])
        );
    end

    always_comb duty_a = rom_mag[0];
    always_comb duty_b = rom_mag[1];

    // R4/R5: at home, winding A is full and winding B is off.
    p_home_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !home_n |-> (duty_a == 8'd255 && duty_b == 8'd0 && phase == 4'b1010));
    // R7: on a quadrant boundary one winding is full and the other is off.
    p_axis_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr[QTR_LOG-1:0] == '0) |->
        ((duty_a == 8'd255 && duty_b == 8'd0) || (duty_a == 8'd0 && duty_b == 8'd255)));
    // R8: outputs change only in the cycle the step notice is raised.
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_taken && $past(rst_n) |-> $stable(phase) && $stable(duty_a) && $stable(duty_b));
endmodule

// File: tb/sim_ustep_sequencer.sv
`timescale 1ns/100ps
module sim_ustep_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_n = 1'b1;
    logic       dir = 1'b1;
    logic [2:0] mode = 3'd0;
    logic [3:0] phase;
    logic [7:0] duty_a;
    logic [7:0] duty_b;
    logic       home_n;
    logic       step_taken;

    int  n_chk = 0;
    int  n_bad = 0;
    int  exp_ptr = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    ustep_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .step_n(step_n), .dir(dir), .mode(mode),
        .phase(phase), .duty_a(duty_a), .duty_b(duty_b), .home_n(home_n),
        .step_taken(step_taken)
    );

    function automatic int stride_of(input logic [2:0] m);
        return (m >= 3'd5) ? 1 : (32 >> m);
    endfunction

    function automatic int mag_of(input real x);
        real a;
        a = (x < 0.0) ? -x : x;
        return $rtoi(255.0 * a + 0.5);
    endfunction

    function automatic logic [3:0] phase_of(input int p);
        case (p / 32)
            0: return 4'b1010;
            1: return 4'b0110;
            2: return 4'b0101;
            default: return 4'b1001;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_outputs(input string req);
        real ang;
        int  ea, eb;
        ang = exp_ptr * 3.14159265358979 / 64.0;
        ea  = mag_of($cos(ang));
        eb  = mag_of($sin(ang));
        chk(phase == phase_of(exp_ptr), {req, " R6 phase"}, phase, phase_of(exp_ptr));
        chk(duty_a == ea, {req, " R7 duty_a"}, duty_a, ea);
        chk(duty_b == eb, {req, " R7 duty_b"}, duty_b, eb);
        chk(home_n == (exp_ptr != 0), {req, " R5 home_n"}, home_n, (exp_ptr != 0));
    endtask

    task automatic do_step(input logic d, input logic [2:0] m, input string req);
        int pulses;
        pulses = 0;
        @(negedge clk);
        dir = d;
        mode = m;
        step_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (step_taken) pulses++;
        end
        step_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (step_taken) pulses++;
        end
        exp_ptr = d ? (exp_ptr + stride_of(m)) % 128 : (exp_ptr - stride_of(m) + 128) % 128;
        chk(pulses == 1, {req, " R8 step_taken pulses"}, pulses, 1);
        check_outputs(req);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_ptr = 0;
        @(negedge clk);
    endtask

    // R8 latency: outputs must not move before the third edge, then move on it.
    task automatic check_latency();
        @(negedge clk);
        dir = 1'b1;
        mode = 3'd5;
        step_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(home_n == 1'b0, "R8 no move after two edges", home_n, 0);
        @(negedge clk);
        chk(home_n == 1'b1 && step_taken, "R8 move on third edge", {home_n, step_taken}, 3);
        repeat (8) @(negedge clk);
        step_n = 1'b1;
        repeat (10) @(negedge clk);
        exp_ptr = 1;
        check_outputs("R8 latency end");
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1d5e7);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R4 reset state");
        chk(duty_a == 8'd255 && duty_b == 8'd0, "R4 home duty", duty_a, 255);

        do_step(1'b0, 3'd0, "R3 reverse wrap 0 to 96");
        do_step(1'b1, 3'd0, "R3 forward back to 0");
        do_step(1'b1, 3'd5, "R1 code 101");
        do_step(1'b1, 3'd6, "R1 code 110");
        do_step(1'b1, 3'd7, "R1 code 111");
        do_step(1'b1, 3'd0, "R9 full from odd slot");
        chk(exp_ptr == 35, "R9 expected slot", exp_ptr, 35);
        do_step(1'b1, 3'd1, "R2 half");
        do_step(1'b1, 3'd2, "R2 quarter");
        do_step(1'b1, 3'd3, "R2 eighth");
        do_step(1'b1, 3'd4, "R2 sixteenth");
        do_step(1'b0, 3'd4, "R2 sixteenth reverse");

        apply_reset();
        check_outputs("R4 reset mid run");
        do_step(1'b0, 3'd7, "R3 reverse wrap to 127");
        do_step(1'b1, 3'd5, "R3 forward wrap to 0");
        do_step(1'b1, 3'd4, "R2 two slots");
        do_step(1'b1, 3'd4, "R2 two slots");
        do_step(1'b1, 3'd4, "R2 two slots");
        do_step(1'b1, 3'd4, "R2 two slots");
        do_step(1'b1, 3'd4, "R2 two slots");
        do_step(1'b1, 3'd4, "R2 two slots");
        do_step(1'b1, 3'd4, "R2 two slots");
        do_step(1'b1, 3'd4, "R7 slot 16");
        chk(duty_a == 8'd180 && duty_b == 8'd180, "R7 slot 16 both 180", duty_a, 180);

        apply_reset();
        check_latency();

        for (int k = 0; k < 400; k++) begin
            logic       d;
            logic [2:0] m;
            d = 1'($urandom % 2);
            m = 3'($urandom % 8);
            do_step(d, m, "R3 random step");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule